// File: doc/BRIEF.md
# Serial Controller Interrupt Mask and Event Latch

This block sits next to a serial controller's datapath and turns its thirteen event lines into one processor interrupt. Each event line is caught in a sticky pending bit. The pending bit holds until software writes a 1 to it at the pending-bit address. A separate enable vector selects which pending bits may raise the interrupt. Software cannot write the enable vector directly. It writes 1s at a set address to turn sources on, and 1s at a reset address to turn them off.

All access goes through one 32-bit word port with a write strobe and a combinational read. Reads of the set and reset addresses always return zero. A fifth, read-only address shows four of the event lines as they are right now, whether or not they are enabled. Software uses it to poll receive and transmit fill conditions without taking an interrupt. The interrupt output is registered. The asynchronous reset is released on the clock through a two-stage synchronizer.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A write at byte offset 0x08 sets every enable bit whose data bit is 1. Enable bits written as 0 keep their value.
- R2: A write at byte offset 0x0C clears every enable bit whose data bit is 1. Enable bits written as 0 keep their value.
- R3: A read at offset 0x08 or offset 0x0C returns 0x00000000.
- R4: Offset 0x10 reads back the enable vector and offset 0x14 reads back the pending vector. Both are 13 bits wide in bits 12:0. Bits 31:13 of every read are 0, and write data bits 31:13 have no effect.
- R5: A pending bit is set on the clock edge at which its event line is high. It then stays set until software clears it.
- R6: A write at offset 0x14 clears each pending bit whose data bit is 1. Pending bits written as 0 stay as they are.
- R7: When an event line is high on the same edge that a write clears its pending bit, the pending bit ends up set.
- R8: The interrupt output is high in the cycle after any bit is both pending and enabled, and low in the cycle after no bit is.
- R9: Offset 0x2C reads the live event lines 0, 1, 3 and 4 in those same bit positions, independent of the enable vector. All other bits of this read are 0.
- R10: After reset the enable vector, the pending vector and the interrupt output are all zero.
- R11: Writes to offsets 0x10 and 0x2C, and writes to any unmapped offset, change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the word at addr_i |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| evt_i | input | 13 | Event lines from the serial datapath |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is an event line rising on the very edge at which software writes 1 to the same pending bit. From the ports, this needs an event pulse lined up with a write to the pending address. Random stimulus rarely puts a set and a clear of the same bit on the same cycle. The bench therefore forces this case with a directed step, and it also biases random writes toward the pending address while the event lines stay sparse. A second subtle case is the one-cycle lag of the interrupt. The bench models it by computing the next interrupt value from the pending and enable state as it stood before each edge.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

  localparam logic [11:0] OFS_EN_SET = 12'h008;
  localparam logic [11:0] OFS_EN_CLR = 12'h00C;
  localparam logic [11:0] OFS_EN_RD  = 12'h010;
  localparam logic [11:0] OFS_PEND   = 12'h014;
  localparam logic [11:0] OFS_LIVE   = 12'h02C;

  // event lines visible at the live-level address
  localparam int unsigned EVB_RX_TRIG  = 0;
  localparam int unsigned EVB_RX_EMPTY = 1;
  localparam int unsigned EVB_TX_EMPTY = 3;
  localparam int unsigned EVB_TX_FULL  = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EN_SET,
    SEL_EN_CLR,
    SEL_EN_RD,
    SEL_PEND,
    SEL_LIVE
  } reg_sel_e;

endpackage

// File: rtl/uart_irq_decode.sv
`timescale 1ns/1ps
module uart_irq_decode
  import uart_irq_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o
);

  always_comb begin
    sel_o = SEL_NONE;
    if      (addr_i == AW'(OFS_EN_SET)) sel_o = SEL_EN_SET;
    else if (addr_i == AW'(OFS_EN_CLR)) sel_o = SEL_EN_CLR;
    else if (addr_i == AW'(OFS_EN_RD))  sel_o = SEL_EN_RD;
    else if (addr_i == AW'(OFS_PEND))   sel_o = SEL_PEND;
    else if (addr_i == AW'(OFS_LIVE))   sel_o = SEL_LIVE;
  end

endmodule

// File: rtl/uart_irq_enable.sv
`timescale 1ns/1ps
module uart_irq_enable #(
  parameter int unsigned NSRC = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_stb_i,
  input  logic            clr_stb_i,
  input  logic [NSRC-1:0] wbits_i,
  output logic [NSRC-1:0] en_o
);

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_d;
  logic            en_upd;

  always_comb begin
    en_d = en_q;
    if (set_stb_i) en_d = en_d | wbits_i;
    if (clr_stb_i) en_d = en_d & ~wbits_i;
  end

  assign en_upd = set_stb_i | clr_stb_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end

  assign en_o = en_q;

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb_i |=> ((en_o & $past(wbits_i)) == $past(wbits_i))); // R1
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb_i |=> ((en_o & $past(wbits_i)) == '0)); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb_i && !clr_stb_i) |=> $stable(en_o)); // R11

endmodule

// File: rtl/uart_irq_pending.sv
`timescale 1ns/1ps
module uart_irq_pending #(
  parameter int unsigned NSRC = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_stb_i,
  input  logic [NSRC-1:0] wbits_i,
  input  logic [NSRC-1:0] evt_i,
  output logic [NSRC-1:0] pend_o
);

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic [NSRC-1:0] clr_bits;
  logic            pend_upd;

  assign clr_bits = clr_stb_i ? wbits_i : '0;

  // an arriving event overrides a clear of the same bit
  always_comb begin
    pend_d = (pend_q & ~clr_bits) | evt_i;
  end

  assign pend_upd = clr_stb_i | (|evt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= '0;
    else if (pend_upd) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_PEND_CATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((pend_o & $past(evt_i)) == $past(evt_i))); // R7
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb_i |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R5
  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb_i && evt_i == '0) |=> ((pend_o & $past(wbits_i)) == '0)); // R6

endmodule

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned AW   = 12,
  parameter int unsigned DW   = 32,
  parameter int unsigned NSRC = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] evt_i,
  output logic            irq_o
);

  localparam logic [NSRC-1:0] LIVE_SEL = NSRC'((1 << EVB_RX_TRIG) | (1 << EVB_RX_EMPTY) |
                                               (1 << EVB_TX_EMPTY) | (1 << EVB_TX_FULL));

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  reg_sel_e        sel;
  logic [NSRC-1:0] wbits;
  logic            set_stb;
  logic            clr_stb;
  logic            pclr_stb;
  logic [NSRC-1:0] en_vec;
  logic [NSRC-1:0] pend_vec;
  logic [NSRC-1:0] rd_bits;
  logic            irq_d;
  logic            irq_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  uart_irq_decode #(.AW(AW)) i_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wbits    = wdata_i[NSRC-1:0];
  assign set_stb  = wr_en_i && (sel == SEL_EN_SET);
  assign clr_stb  = wr_en_i && (sel == SEL_EN_CLR);
  assign pclr_stb = wr_en_i && (sel == SEL_PEND);

  generate
    if (DW > NSRC) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[DW-1:NSRC];
      assign rdata_o = {{(DW-NSRC){1'b0}}, rd_bits};
      AST_READ_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
        rdata_o[DW-1:NSRC] == '0); // R4
    end else begin : g_flat
      assign rdata_o = DW'(rd_bits);
    end
  endgenerate

  uart_irq_enable #(.NSRC(NSRC)) i_enable (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .set_stb_i (set_stb),
    .clr_stb_i (clr_stb),
    .wbits_i   (wbits),
    .en_o      (en_vec)
  );

  uart_irq_pending #(.NSRC(NSRC)) i_pending (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr_stb_i (pclr_stb),
    .wbits_i   (wbits),
    .evt_i     (evt_i),
    .pend_o    (pend_vec)
  );

  always_comb begin
    case (sel)
      SEL_EN_RD: rd_bits = en_vec;
      SEL_PEND:  rd_bits = pend_vec;
      SEL_LIVE:  rd_bits = evt_i & LIVE_SEL;
      default:   rd_bits = '0;
    endcase
  end

  assign irq_d = |(pend_vec & en_vec);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|(pend_vec & en_vec)) |=> irq_o); // R8
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(|(pend_vec & en_vec)) |=> !irq_o); // R8
  AST_WRITE_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel == SEL_EN_SET || sel == SEL_EN_CLR) |-> (rdata_o == '0)); // R3

endmodule

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;

  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;
  localparam int unsigned NS = 13;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic [NS-1:0] evt;
  logic          irq;

  int n_chk;
  int n_bad;

  // bench model state
  logic [NS-1:0] m_en;
  logic [NS-1:0] m_pend;
  logic          m_irq;

  uart_irq_ctrl #(.AW(AW), .DW(DW), .NSRC(NS)) i_uart_irq_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .evt_i   (evt),
    .irq_o   (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    case (a)
      12'h010: return DW'(m_en);
      12'h014: return DW'(m_pend);
      12'h02C: return DW'(evt & 13'h001B);
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [AW-1:0] a);
    case (a)
      12'h008, 12'h00C: return "R3";
      12'h010: return "R1";
      12'h014: return "R5";
      12'h02C: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic cycle(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NS-1:0] e, input string tag);
    logic [DW-1:0] exp_rd;
    logic [NS-1:0] wb;
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; evt = e;
    #5;
    exp_rd = exp_read(a);
    n_chk++;
    if (rdata !== exp_rd) begin
      n_bad++;
      $display("FAIL %s rdata addr=%h act=%h exp=%h", tag, a, rdata, exp_rd);
    end
    n_chk++;
    if (irq !== m_irq) begin
      n_bad++;
      $display("FAIL R8 irq (%s step) act=%b exp=%b", tag, irq, m_irq);
    end
    @(posedge clk);
    wb = d[NS-1:0];
    m_irq = |(m_pend & m_en);
    if (w && a == 12'h008) m_en = m_en | wb;
    if (w && a == 12'h00C) m_en = m_en & ~wb;
    if (w && a == 12'h014) m_pend = m_pend & ~wb;
    m_pend = m_pend | e;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [AW-1:0] alist [7];
    n_chk = 0; n_bad = 0;
    m_en = '0; m_pend = '0; m_irq = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; evt = '0;
    void'($urandom(32'd20240611));
    alist[0] = 12'h008; alist[1] = 12'h00C; alist[2] = 12'h010; alist[3] = 12'h014;
    alist[4] = 12'h02C; alist[5] = 12'h000; alist[6] = 12'h030;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10: reset state
    cycle(1'b0, 12'h010, '0, '0, "R10");
    cycle(1'b0, 12'h014, '0, '0, "R10");
    // R1 and R4: set every bit, upper data bits are dropped
    cycle(1'b1, 12'h008, 32'hFFFF_FFFF, '0, "R1");
    cycle(1'b0, 12'h010, '0, '0, "R4");
    // R2: clear a group
    cycle(1'b1, 12'h00C, 32'h0000_00F0, '0, "R2");
    cycle(1'b0, 12'h010, '0, '0, "R2");
    // R3: write-only addresses read zero
    cycle(1'b0, 12'h008, '0, '0, "R3");
    cycle(1'b0, 12'h00C, '0, '0, "R3");
    // R5 and R8: event on enabled bit 8
    cycle(1'b0, 12'h014, '0, 13'h0100, "R5");
    cycle(1'b0, 12'h014, '0, '0, "R5");
    cycle(1'b0, 12'h014, '0, '0, "R8");
    // R6: clear it, interrupt drops a cycle later
    cycle(1'b1, 12'h014, 32'h0000_0100, '0, "R6");
    cycle(1'b0, 12'h014, '0, '0, "R6");
    cycle(1'b0, 12'h014, '0, '0, "R8");
    // R7: event and clear of bit 6 on the same edge
    cycle(1'b0, 12'h014, '0, 13'h0040, "R7");
    cycle(1'b1, 12'h014, 32'h0000_0040, 13'h0040, "R7");
    cycle(1'b0, 12'h014, '0, '0, "R7");
    // R9: live levels regardless of enables
    cycle(1'b1, 12'h00C, 32'hFFFF_FFFF, '0, "R9");
    cycle(1'b0, 12'h02C, '0, 13'h1FFF, "R9");
    cycle(1'b0, 12'h02C, '0, 13'h0005, "R9");
    // R11: read-only and unmapped writes change nothing
    cycle(1'b1, 12'h010, 32'hFFFF_FFFF, '0, "R11");
    cycle(1'b1, 12'h02C, 32'hFFFF_FFFF, '0, "R11");
    cycle(1'b1, 12'h018, 32'hFFFF_FFFF, '0, "R11");
    cycle(1'b0, 12'h010, '0, '0, "R11");
    cycle(1'b0, 12'h014, '0, '0, "R11");
    cycle(1'b0, 12'h030, '0, '0, "R11");

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      logic          w;
      logic [NS-1:0] e;
      int unsigned   pick;
      pick = $urandom_range(0, 9);
      if (pick < 7) a = alist[pick];
      else if (pick < 9) a = 12'h014;
      else a = AW'($urandom);
      w = ($urandom_range(0, 1) == 1);
      e = NS'($urandom & $urandom & $urandom);
      cycle(w, a, $urandom, e, tag_of(a));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule